// File: doc/BRIEF.md
# Open-Drain Sensor Line Interval Timer

This block is the host end of a single shared sensor wire that has an external pull-up. The controller never drives the wire high. It has one pad control, `line_oe`, and while that control is asserted the pad pulls the wire to ground. When the control is off, the pull-up returns the wire to its idle high level. The pad's output data is tied low outside this block.

A measurement starts when `enable` is seen in the idle state. The controller then pulls the wire low for a fixed number of cycles and releases it. A sensor answers by pulling the wire low. The time from the wire going high again to that answer carries the measured value.

The wire is asynchronous to the clock, so it passes through a flop synchronizer first. Any input that is not a clean low is read as high, which matches the pull-up. The elapsed count is split into two fields: a slot index (the upper bits) and an offset inside that slot (the lower bits). This lets up to `NUM_SLOTS` devices answer in separate windows on the same wire. If nobody answers, the counter reaches its last value and the controller goes back to idle without reporting anything.

Top module: `sense_line_timer`

## Requirements
- R1: After reset, `line_oe`, `meas_valid`, `meas_slot` and `meas_offset` are all 0, and `line_oe` stays 0 for as long as `enable` stays low.
- R2: When `enable` is sampled high in idle, `line_oe` goes to 1 in the next cycle and stays at 1 for exactly `TRIG_CYCLES` (default 20) consecutive cycles.
- R3: The block asserts `line_oe` only during a trigger pulse. `line_oe` stays 0 while the controller waits for the wire to go high, while it measures, and while a sensor holds its answer.
- R4: The reference cycle is the first cycle after the trigger release in which `line_in` is high. If `line_in` is first low in the D-th cycle after the reference cycle (D ≥ 1), the reported delay is D−1.
- R5: The reported delay is split into two fields. `meas_slot` holds delay >> `SLOT_LOG2` and `meas_offset` holds the low `SLOT_LOG2` bits (defaults: 64-cycle slots, 8 slots, 9-bit counter). A delay of 2^CNT_W−1 (the last count) is still reported.
- R6: `meas_valid` is high for exactly one cycle per answer. `meas_slot` and `meas_offset` change only in a cycle where `meas_valid` is high.
- R7: `meas_valid` rises on the third rising clock edge, counting the first edge at which `line_in` is sampled low for the answer.
- R8: If `line_in` is still low after the trigger release, the controller does not start measuring and reports nothing until the line has gone high. The reference of R4 is then the first high cycle.
- R9: If no answer arrives, the controller reports nothing. With `enable` held high, the next trigger pulse starts 2^CNT_W+4 cycles after the previous pulse ended (516 with defaults).
- R10: After an answer, the controller waits for `line_in` to return high before it goes back to idle. With `enable` held high, the next trigger starts 4 cycles after `line_in` returns high.
- R11: `enable` is sampled only in idle. Dropping it during a trigger or a measurement does not abort that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start request, sampled only while idle |
| line_in | input | 1 | Level read from the shared wire (asynchronous) |
| line_oe | output | 1 | Pad pull-down control: 1 pulls the wire low, 0 releases it |
| meas_slot | output | SLOT_W (3) | Slot index of the last answer |
| meas_offset | output | SLOT_LOG2 (6) | Offset inside the slot of the last answer |
| meas_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Most faults show up on `line_oe` first. A counter off by one or a wrong state exit changes the length of the trigger pulse, or shifts the start of the next pulse, at the very next trigger. A wrong synchronizer depth or reference point moves both the reported count and the strobe cycle by whole cycles, so the scoreboard compares each result's value and its arrival cycle. A broken timeout or a missing wait-for-high path shows up within one counter period, either as a stray strobe or as a trigger that starts while the sensor still holds the line.

// File: rtl/sense_line_pkg.sv
package sense_line_pkg;

    // Controller phases
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start request
        ST_TRIG = 3'd1,   // pulling the wire low
        ST_REL  = 3'd2,   // released, waiting to see the wire high
        ST_MEAS = 3'd3,   // counting until a sensor answers
        ST_DONE = 3'd4    // answer seen, waiting for the wire to recover
    } line_state_e;

endpackage

// File: rtl/sense_line_sync.sv
module sense_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic level,
    output logic fell
);

    logic              clean;
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;
    logic              prev_d;
    logic              prev_q;

    // Only a clean low counts as low; anything else reads as pulled up.
    always_comb begin
        clean = (pad_in === 1'b0) ? 1'b0 : 1'b1;
    end

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = clean;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], clean};
        end
    endgenerate

    always_comb begin
        level  = chain_q[STAGES-1];
        prev_d = level;
        fell   = prev_q & ~level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    // R7
    sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level) |-> ($past(clean, STAGES) == 1'b0));

endmodule

// File: rtl/sense_line_slotmap.sv
module sense_line_slotmap #(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_LOG2 = 6,
    parameter int SLOT_W    = 3,
    parameter int CNT_W     = 9
) (
    input  logic [CNT_W-1:0]     count,
    output logic [SLOT_W-1:0]    slot,
    output logic [SLOT_LOG2-1:0] offset
);

    always_comb offset = count[SLOT_LOG2-1:0];

    generate
        if (NUM_SLOTS > 1) begin : g_multi
            always_comb slot = count[CNT_W-1:SLOT_LOG2];
        end else begin : g_single
            always_comb slot = '0;
        end
    endgenerate

endmodule

// File: rtl/sense_line_timer.sv
module sense_line_timer
    import sense_line_pkg::*;
#(
    parameter int TRIG_CYCLES = 20,
    parameter int SLOT_LOG2   = 6,
    parameter int NUM_SLOTS   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SLOT_BITS  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 0,
    localparam int SLOT_W     = (SLOT_BITS > 0) ? SLOT_BITS : 1,
    localparam int CNT_W      = SLOT_LOG2 + SLOT_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 line_in,
    output logic                 line_oe,
    output logic [SLOT_W-1:0]    meas_slot,
    output logic [SLOT_LOG2-1:0] meas_offset,
    output logic                 meas_valid
);

    localparam logic [CNT_W-1:0] TRIG_LAST = CNT_W'(TRIG_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    typedef struct packed {
        line_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             oe;
        logic             vld;
        logic [CNT_W-1:0] res;
    } ctl_t;

    ctl_t r_d;
    ctl_t r_q;
    logic line_hi;
    logic line_fell;

    sense_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (line_in),
        .level  (line_hi),
        .fell   (line_fell)
    );

    sense_line_slotmap #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_LOG2 (SLOT_LOG2),
        .SLOT_W    (SLOT_W),
        .CNT_W     (CNT_W)
    ) u_slotmap (
        .count  (r_q.res),
        .slot   (meas_slot),
        .offset (meas_offset)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.cnt = r_q.cnt + 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cnt = '0;
                if (enable) begin
                    r_d.st = ST_TRIG;
                    r_d.oe = 1'b1;
                end
            end
            ST_TRIG: begin
                if (r_q.cnt == TRIG_LAST) begin
                    r_d.st = ST_REL;
                    r_d.oe = 1'b0;
                end
            end
            ST_REL: begin
                if (line_hi) begin
                    r_d.st  = ST_MEAS;
                    r_d.cnt = '0;
                end else if (r_q.cnt == CNT_MAX) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_MEAS: begin
                // An answer on the last count wins over the timeout.
                if (line_fell) begin
                    r_d.st  = ST_DONE;
                    r_d.vld = 1'b1;
                    r_d.res = r_q.cnt;
                end else if (r_q.cnt == CNT_MAX) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_DONE: begin
                if (line_hi || r_q.cnt == CNT_MAX) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
                r_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
            r_q.oe  <= 1'b0;
            r_q.vld <= 1'b0;
            r_q.res <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        line_oe    = r_q.oe;
        meas_valid = r_q.vld;
    end

    // Length of the current run of pull-down cycles, for the checks below.
    logic [31:0] oe_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       oe_run_q <= '0;
        else if (line_oe) oe_run_q <= oe_run_q + 1;
        else              oe_run_q <= '0;
    end

    // R2
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && enable) |=> line_oe);

    // R3
    oe_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_run_q <= 32'(TRIG_CYCLES));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> ($stable(meas_slot) && $stable(meas_offset)));

    // R8
    no_early_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REL && !line_hi) |=> !meas_valid);

    // R9
    timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MEAS && !line_fell && r_q.cnt == CNT_MAX) |=> (!meas_valid && !line_oe));

endmodule

// File: tb/sense_line_timer_test.sv
module sense_line_timer_test;

    localparam int TRIG = 20;
    localparam int L    = 6;
    localparam int SW   = 3;
    localparam int CW   = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          sensor_pull = 1'b0;
    logic          line_oe;
    logic          meas_valid;
    logic [SW-1:0] meas_slot;
    logic [L-1:0]  meas_offset;
    wire           line_in = ~(line_oe | sensor_pull);

    sense_line_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .line_in     (line_in),
        .line_oe     (line_oe),
        .meas_slot   (meas_slot),
        .meas_offset (meas_offset),
        .meas_valid  (meas_valid)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int delay;
        int due;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard pops, strobe width, trigger pulse length
    bit prev_valid = 1'b0;
    int oe_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (meas_valid) begin
                check(!prev_valid, "R6", "strobe wider than one cycle", 2, 1);
                if (sbq.size() == 0) begin
                    check(1'b0, "R9", "unexpected result strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(int'(meas_slot) == (e.delay >> L), "R5", "slot index",
                          int'(meas_slot), e.delay >> L);
                    check(int'(meas_offset) == (e.delay % (1 << L)), "R4", "offset",
                          int'(meas_offset), e.delay % (1 << L));
                    check(cyc == e.due, "R7", "strobe cycle", cyc, e.due);
                end
            end
            prev_valid = meas_valid;
            if (line_oe) begin
                oe_run++;
            end else if (oe_run > 0) begin
                check(oe_run == TRIG, "R2", "trigger pulse length", oe_run, TRIG);
                oe_run = 0;
            end
        end
    end

    // Driver: one trigger and one sensor answer
    task automatic measure(input int d, input int h, input int p, input bit hold_en);
        bit oe_bad = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        check(line_oe == 1'b1, "R2", "pull-down one cycle after enable", line_oe, 1);
        if (!hold_en) enable = 1'b0;
        while (line_oe) @(negedge clk);
        if (h > 0) begin
            sensor_pull = 1'b1;            // R8: sensor still holds the line
            repeat (h) begin
                @(negedge clk);
                if (line_oe) oe_bad = 1'b1;
            end
            sensor_pull = 1'b0;
        end
        repeat (d) begin
            @(negedge clk);
            if (line_oe) oe_bad = 1'b1;
        end
        sensor_pull = 1'b1;
        sbq.push_back('{delay: d - 1, due: cyc + 3});
        repeat (3) @(negedge clk);
        if (!hold_en)
            check(meas_valid == 1'b1, "R11", "result after enable dropped", meas_valid, 1);
        repeat (p - 3) begin
            @(negedge clk);
            if (line_oe) oe_bad = 1'b1;
        end
        sensor_pull = 1'b0;
        check(!oe_bad, "R3", "pull-down outside trigger", oe_bad, 0);
    endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int k;
        bit any_oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_oe == 1'b0, "R1", "reset line_oe", line_oe, 0);
        check(meas_valid == 1'b0, "R1", "reset meas_valid", meas_valid, 0);
        check(meas_slot == '0 && meas_offset == '0, "R1", "reset result",
              int'({meas_slot, meas_offset}), 0);
        any_oe = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (line_oe) any_oe = 1'b1;
        end
        check(!any_oe, "R1", "pull-down with enable low", any_oe, 0);

        // R4 R5: delays across slot boundaries, including the last count
        measure(1, 0, 8, 1'b0);   repeat (6) @(negedge clk);
        measure(40, 0, 8, 1'b0);  repeat (6) @(negedge clk);
        measure(64, 0, 8, 1'b0);  repeat (6) @(negedge clk);
        measure(65, 0, 8, 1'b0);  repeat (6) @(negedge clk);
        measure(200, 0, 8, 1'b0); repeat (6) @(negedge clk);
        measure(459, 0, 8, 1'b0); repeat (6) @(negedge clk);
        measure(512, 0, 8, 1'b0); repeat (6) @(negedge clk);

        // R8: line held low past the release
        measure(30, 15, 6, 1'b0); repeat (6) @(negedge clk);

        // R10: enable held, next trigger waits for line recovery
        measure(10, 0, 12, 1'b1);
        k = 0;
        while (!line_oe) begin
            @(negedge clk);
            k++;
        end
        enable = 1'b0;
        check(k == 4, "R10", "cycles from line high to next trigger", k, 4);
        repeat (600) @(negedge clk);

        // R9: no answer, timeout then fresh trigger
        enable = 1'b1;
        @(negedge clk);
        check(line_oe == 1'b1, "R2", "pull-down one cycle after enable", line_oe, 1);
        while (line_oe) @(negedge clk);
        k = 0;
        while (!line_oe) begin
            @(negedge clk);
            k++;
        end
        enable = 1'b0;
        check(k == (1 << CW) + 4, "R9", "timeout restart spacing", k, (1 << CW) + 4);
        repeat (600) @(negedge clk);

        check(sbq.size() == 0, "R4", "results never reported", sbq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule